// File: doc/BRIEF.md
# Multiplexed PSRAM Bus-Cycle Decoder

This block sits on the device side of a pseudo-static RAM whose address and data share one 16-bit bus. It watches the control pins (address-valid, chip enable, output enable, write enable, configuration-register enable and the two byte selects). It names the bus cycle in progress and drives the enables for the shared bus and for the WAIT pin. The downstream array controller receives each decoded cycle as a one-hot operation vector with a valid strobe. The strobe carries no ready and there is no back-pressure: the consumer must act on every cycle in which `op_valid` is high, and idle, standby and power-down never raise it.

Two configuration registers live inside the block. The bus register holds the operating-mode bit (bit 15) and the WAIT polarity bit (bit 10). The refresh register holds the power-down arm bit (bit 4). In asynchronous mode the cycle is decoded combinationally from the pin levels. In burst mode the pins are sampled on the rising edge of `clk`, and the decoded cycle appears after that edge. Deep power-down is armed by clearing the arm bit and entered on the next rising edge of chip enable. Only a falling edge of chip enable leaves it.

Top module: `psram_cycle_decoder`

## Requirements
- R1: After reset the bus register reads 16'h8400 (bit 15 = 1 selects asynchronous mode, bit 10 = 1 makes WAIT active-high). The refresh register reads 16'h0010. `burst_mode` and `in_dpd` are low and the decoded operation is standby.
- R2: In asynchronous mode, with `ce_n` low and `cre` low, `we_n` low decodes a write whatever `oe_n` is, with `dq_oe` and `wait_oe` low. `oe_n` low with `we_n` high decodes a read, with `dq_oe` and `wait_oe` high.
- R3: With `ce_n` high and outside power-down, the operation is standby. `op_valid`, `dq_oe`, `wait_oe` and `lane_en` are all low, and no register write takes effect. A write attempted during power-down is also ignored.
- R4: With `cre` high in an active cycle, `we_n` low writes `adq_in` into the bus register when `reg_sel` = 1 and into the refresh register when `reg_sel` = 0. `oe_n` low with `we_n` high is a register read that places the selected register on `cfg_rdata` and raises `dq_oe`.
- R5: In burst mode, a rising `clk` edge that sees `ce_n` low, `adv_n` low and `cre` low yields an initial burst write (`we_n` low) or an initial burst read (`we_n` high) after that edge. `dq_oe` is low because the bus carries the address.
- R6: In burst mode, an edge with `adv_n` high and `ce_n` low yields burst-continue if an initial cycle has been seen since chip enable last fell away, and idle otherwise. Burst-continue drives `dq_oe` only for a read burst.
- R7: `lane_en[0]` (DQ[7:0]) is high when `byte_sel_n[0]` is low, and `lane_en[1]` (DQ[15:8]) is high when `byte_sel_n[1]` is low, during any access operation. Otherwise both are zero.
- R8: `wait_o` equals `wait_req` when bus-register bit 10 is 1 and its inverse when that bit is 0. `wait_oe` is low only for asynchronous writes, standby and power-down.
- R9: Power-down begins at the clock edge that sees a rising edge of `ce_n` while refresh bit 4 is 0, and ends at the edge that sees the next falling edge of `ce_n`. The exit sets refresh bit 4 back to 1. While in power-down the operation is DPD.
- R10: `op_vec` is always one-hot, with bit index idle 0, standby 1, DPD 2, async read 3, async write 4, burst-initial read 5, burst-initial write 6, burst-continue 7, register read 8, register write 9. `op_valid` is high exactly for indices 3 to 9.
- R11: In asynchronous mode, a pin change shows on `op_vec`, `dq_oe` and `lane_en` before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; samples burst cycles and all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_n | input | 1 | Address-valid, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cre | input | 1 | Configuration-register access enable |
| byte_sel_n | input | 2 | Byte selects, bit 0 lower byte, bit 1 upper byte, active low |
| reg_sel | input | 1 | Register-select address bit: 1 bus register, 0 refresh register |
| adq_in | input | 16 | Incoming value on the shared bus |
| wait_req | input | 1 | Array controller requests WAIT asserted |
| op_vec | output | 10 | One-hot decoded operation |
| op_valid | output | 1 | Decoded operation is an access |
| dq_oe | output | 1 | Drive the shared bus |
| lane_en | output | 2 | Enabled byte lanes |
| wait_oe | output | 1 | Drive the WAIT pin |
| wait_o | output | 1 | Level driven on WAIT |
| cfg_rdata | output | 16 | Selected configuration register contents |
| burst_mode | output | 1 | Burst mode is selected |
| in_dpd | output | 1 | Deep power-down active |

## Verification
The bench takes the decoder through a mode switch made by a register write. If the new mode took effect in the same cycle as the write, the registered operation shown after the edge would be wrong. It issues a burst-continue pattern with no preceding initial cycle, which a decoder that does not track burst state would report as data. It arms, enters and leaves power-down, and attempts a register write while powered down. A design that skipped the arm-bit restore would fall back into power-down at the next chip-enable release. A design that let pins through during power-down would end up in the wrong mode. The polarity flip of WAIT and write cycles with output enable also low are applied as well.

// File: rtl/psram_dec_pkg.sv
package psram_dec_pkg;
  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_STANDBY = 4'd1,
    OP_DPD     = 4'd2,
    OP_ARD     = 4'd3,
    OP_AWR     = 4'd4,
    OP_BIRD    = 4'd5,
    OP_BIWR    = 4'd6,
    OP_BCONT   = 4'd7,
    OP_CRD     = 4'd8,
    OP_CWR     = 4'd9
  } op_e;

  localparam int NUM_OPS = 10;

  typedef struct packed {
    logic adv_n;
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic cre;
  } ctl_pins_t;
endpackage

// File: rtl/psram_cyc_classify.sv
module psram_cyc_classify
  import psram_dec_pkg::*;
(
  input  logic      burst_mode,
  input  logic      dpd,
  input  logic      burst_act,
  input  ctl_pins_t pins,
  output op_e       nxt_op
);
  always_comb begin
    if (dpd) begin
      nxt_op = OP_DPD;
    end else if (pins.ce_n) begin
      nxt_op = OP_STANDBY;
    end else if (!burst_mode) begin
      // level-decoded cycles
      if (pins.cre)
        nxt_op = !pins.we_n ? OP_CWR : (!pins.oe_n ? OP_CRD : OP_IDLE);
      else
        nxt_op = !pins.we_n ? OP_AWR : (!pins.oe_n ? OP_ARD : OP_IDLE);
    end else if (!pins.adv_n) begin
      // address phase of a clocked cycle
      if (pins.cre)
        nxt_op = !pins.we_n ? OP_CWR : (!pins.oe_n ? OP_CRD : OP_IDLE);
      else
        nxt_op = !pins.we_n ? OP_BIWR : OP_BIRD;
    end else begin
      nxt_op = burst_act ? OP_BCONT : OP_IDLE;
    end
  end
endmodule

// File: rtl/psram_cfg_dpd.sv
module psram_cfg_dpd #(
  parameter int          DATA_W  = 16,
  parameter int          DPD_BIT = 4,
  parameter logic [15:0] BCR_RST = 16'h8400,
  parameter logic [15:0] RCR_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ce_n,
  output logic [DATA_W-1:0] bus_reg,
  output logic [DATA_W-1:0] ref_reg,
  output logic              dpd
);
  logic ce_q;
  logic ce_rise, ce_fall;

  assign ce_rise = !ce_q && ce_n;
  assign ce_fall = ce_q && !ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_reg <= DATA_W'(BCR_RST);
      ref_reg <= DATA_W'(RCR_RST);
      dpd     <= 1'b0;
      ce_q    <= 1'b1;
    end else begin
      ce_q <= ce_n;
      if (dpd) begin
        if (ce_fall) begin
          dpd              <= 1'b0;
          ref_reg[DPD_BIT] <= 1'b1;
        end
      end else begin
        if (cfg_we) begin
          if (cfg_sel) bus_reg <= wdata;
          else         ref_reg <= wdata;
        end
        if (ce_rise && !ref_reg[DPD_BIT]) dpd <= 1'b1;
      end
    end
  end

  assert_dpd_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && ce_rise && !ref_reg[DPD_BIT]) |=> dpd);

  assert_dpd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dpd && ce_fall) |=> (!dpd && ref_reg[DPD_BIT]));

  assert_cfg_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && cfg_we && cfg_sel) |=> (bus_reg == $past(wdata)));
endmodule

// File: rtl/psram_bus_drive.sv
module psram_bus_drive
  import psram_dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  op_e                op,
  input  logic               burst_rd,
  input  logic [LANES-1:0]   bsel_n,
  input  logic               wait_req,
  input  logic               wait_pol,
  output logic [NUM_OPS-1:0] op_vec,
  output logic               op_valid,
  output logic               dq_oe,
  output logic [LANES-1:0]   lane_en,
  output logic               wait_oe,
  output logic               wait_o
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_onehot
    assign op_vec[g] = (int'(op) == g);
  end

  always_comb begin
    op_valid = 1'b0;
    dq_oe    = 1'b0;
    wait_oe  = 1'b1;
    unique case (op)
      OP_ARD, OP_CRD: begin op_valid = 1'b1; dq_oe = 1'b1; end
      OP_AWR:         begin op_valid = 1'b1; wait_oe = 1'b0; end
      OP_BIRD, OP_BIWR, OP_CWR: op_valid = 1'b1;
      OP_BCONT:       begin op_valid = 1'b1; dq_oe = burst_rd; end
      OP_STANDBY, OP_DPD: wait_oe = 1'b0;
      default: ;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = op_valid && !bsel_n[g];
  end

  assign wait_o = wait_pol ? wait_req : !wait_req;
endmodule

// File: rtl/psram_cycle_decoder.sv
module psram_cycle_decoder
  import psram_dec_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          MODE_BIT = 15,
  parameter int          POL_BIT  = 10,
  parameter int          DPD_BIT  = 4,
  parameter logic [15:0] BCR_RST  = 16'h8400,
  parameter logic [15:0] RCR_RST  = 16'h0010,
  localparam int         LANES    = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_n,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic               cre,
  input  logic [LANES-1:0]   byte_sel_n,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  adq_in,
  input  logic               wait_req,
  output logic [NUM_OPS-1:0] op_vec,
  output logic               op_valid,
  output logic               dq_oe,
  output logic [LANES-1:0]   lane_en,
  output logic               wait_oe,
  output logic               wait_o,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               burst_mode,
  output logic               in_dpd
);
  ctl_pins_t         pins;
  op_e               nxt_op, op_q, op_out;
  logic [LANES-1:0]  bsel_q, bsel_eff;
  logic              sel_q, sel_eff;
  logic              burst_act, burst_rd;
  logic [DATA_W-1:0] bus_reg, ref_reg;

  assign pins       = '{adv_n: adv_n, ce_n: ce_n, oe_n: oe_n, we_n: we_n, cre: cre};
  assign burst_mode = !bus_reg[MODE_BIT];

  psram_cyc_classify u_cls (
    .burst_mode (burst_mode),
    .dpd        (in_dpd),
    .burst_act  (burst_act),
    .pins       (pins),
    .nxt_op     (nxt_op)
  );

  psram_cfg_dpd #(
    .DATA_W (DATA_W), .DPD_BIT (DPD_BIT),
    .BCR_RST (BCR_RST), .RCR_RST (RCR_RST)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (nxt_op == OP_CWR),
    .cfg_sel (reg_sel),
    .wdata   (adq_in),
    .ce_n    (ce_n),
    .bus_reg (bus_reg),
    .ref_reg (ref_reg),
    .dpd     (in_dpd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_STANDBY;
      bsel_q    <= '1;
      sel_q     <= 1'b0;
      burst_act <= 1'b0;
      burst_rd  <= 1'b0;
    end else begin
      op_q   <= nxt_op;
      bsel_q <= byte_sel_n;
      sel_q  <= reg_sel;
      unique case (nxt_op)
        OP_BIRD:  begin burst_act <= 1'b1; burst_rd <= 1'b1; end
        OP_BIWR:  begin burst_act <= 1'b1; burst_rd <= 1'b0; end
        OP_BCONT: ;
        default:  burst_act <= 1'b0;
      endcase
    end
  end

  assign op_out    = in_dpd ? OP_DPD : (burst_mode ? op_q : nxt_op);
  assign bsel_eff  = burst_mode ? bsel_q : byte_sel_n;
  assign sel_eff   = burst_mode ? sel_q : reg_sel;
  assign cfg_rdata = sel_eff ? bus_reg : ref_reg;

  psram_bus_drive #(.LANES (LANES)) u_drv (
    .op       (op_out),
    .burst_rd (burst_rd),
    .bsel_n   (bsel_eff),
    .wait_req (wait_req),
    .wait_pol (bus_reg[POL_BIT]),
    .op_vec   (op_vec),
    .op_valid (op_valid),
    .dq_oe    (dq_oe),
    .lane_en  (lane_en),
    .wait_oe  (wait_oe),
    .wait_o   (wait_o)
  );

  assert_onehot_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(op_vec) == 1);

  assert_async_write_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode && !in_dpd && !ce_n && !cre && !we_n) |-> (!dq_oe && !wait_oe && op_valid));

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_vec[OP_STANDBY] |-> (!op_valid && !dq_oe && !wait_oe && lane_en == '0));

  assert_burst_init_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && !in_dpd && !ce_n && !adv_n && !cre && !we_n) |=> op_vec[OP_BIWR]);
endmodule

// File: tb/tb_psram_cycle_decoder.sv
`timescale 1ns/100ps
module tb_psram_cycle_decoder;
  localparam logic [3:0] X_IDLE = 4'd0, X_STBY = 4'd1, X_DPD = 4'd2, X_ARD = 4'd3,
                         X_AWR = 4'd4, X_BIRD = 4'd5, X_BIWR = 4'd6, X_BCONT = 4'd7,
                         X_CRD = 4'd8, X_CWR = 4'd9;

  typedef struct packed {
    logic adv_n; logic ce_n; logic oe_n; logic we_n; logic cre;
    logic [1:0] bsel_n; logic sel; logic [15:0] wdata; logic wreq;
    logic [3:0] x_op; logic x_valid; logic x_dq; logic [1:0] x_lanes;
    logic x_woe; logic x_wo; logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // async mode
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b11,1'b0,16'h0000,1'b0, X_STBY, 1'b0,1'b0,2'b00,1'b0,1'b0, 4'd3},  // R3
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b1, X_ARD,  1'b1,1'b1,2'b11,1'b1,1'b1, 4'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b0,1'b0,2'b10,1'b0,16'h0000,1'b0, X_AWR,  1'b1,1'b0,2'b01,1'b0,1'b0, 4'd7},  // R7
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,1'b0,16'h0000,1'b0, X_AWR,  1'b1,1'b0,2'b10,1'b0,1'b0, 4'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b0, X_IDLE, 1'b0,1'b0,2'b00,1'b1,1'b0, 4'd10}, // R10
    '{1'b1,1'b0,1'b1,1'b0,1'b1,2'b00,1'b1,16'h0000,1'b0, X_CWR,  1'b1,1'b0,2'b11,1'b1,1'b1, 4'd4},  // R4 -> burst, pol low
    // burst mode
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b0, X_BIRD, 1'b1,1'b0,2'b11,1'b1,1'b1, 4'd5},  // R5
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b1, X_BCONT,1'b1,1'b1,2'b11,1'b1,1'b0, 4'd8},  // R8 R6
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'b01,1'b0,16'h0000,1'b0, X_BCONT,1'b1,1'b1,2'b10,1'b1,1'b1, 4'd7},  // R7
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b11,1'b0,16'h0000,1'b0, X_STBY, 1'b0,1'b0,2'b00,1'b0,1'b1, 4'd3},  // R3
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b0, X_IDLE, 1'b0,1'b0,2'b00,1'b1,1'b1, 4'd6},  // R6
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b10,1'b0,16'h0000,1'b0, X_BIWR, 1'b1,1'b0,2'b01,1'b1,1'b1, 4'd5},  // R5
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,1'b0,16'h0000,1'b0, X_BCONT,1'b1,1'b0,2'b01,1'b1,1'b1, 4'd6},  // R6
    '{1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,1'b0,16'h0000,1'b0, X_CWR,  1'b1,1'b0,2'b11,1'b1,1'b1, 4'd9},  // R9 arm
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b11,1'b0,16'h0000,1'b0, X_DPD,  1'b0,1'b0,2'b00,1'b0,1'b1, 4'd9},  // R9 entry
    '{1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,16'h8400,1'b0, X_DPD,  1'b0,1'b0,2'b00,1'b0,1'b1, 4'd9},  // R9 hold
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b0, X_DPD,  1'b0,1'b0,2'b00,1'b0,1'b1, 4'd9},  // R9 exit edge
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,16'h0000,1'b0, X_BIRD, 1'b1,1'b0,2'b11,1'b1,1'b1, 4'd3},  // R3 write in DPD ignored
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b11,1'b0,16'h0000,1'b0, X_STBY, 1'b0,1'b0,2'b00,1'b0,1'b1, 4'd9}   // R9 arm bit restored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, cre = 1'b0;
  logic [1:0] byte_sel_n = 2'b11;
  logic reg_sel = 1'b0, wait_req = 1'b0;
  logic [15:0] adq_in = 16'h0000;
  logic [9:0] op_vec;
  logic op_valid, dq_oe, wait_oe, wait_o, burst_mode, in_dpd;
  logic [1:0] lane_en;
  logic [15:0] cfg_rdata;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  psram_cycle_decoder dut (
    .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .cre(cre), .byte_sel_n(byte_sel_n), .reg_sel(reg_sel), .adq_in(adq_in),
    .wait_req(wait_req), .op_vec(op_vec), .op_valid(op_valid), .dq_oe(dq_oe),
    .lane_en(lane_en), .wait_oe(wait_oe), .wait_o(wait_o), .cfg_rdata(cfg_rdata),
    .burst_mode(burst_mode), .in_dpd(in_dpd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    adv_n = v.adv_n; ce_n = v.ce_n; oe_n = v.oe_n; we_n = v.we_n; cre = v.cre;
    byte_sel_n = v.bsel_n; reg_sel = v.sel; adq_in = v.wdata; wait_req = v.wreq;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_req = 1'b1; reg_sel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 op", 32'(op_vec), 32'(10'b1 << X_STBY));
    check("R1 mode", 32'(burst_mode), 32'd0);
    check("R1 wait pol", 32'(wait_o), 32'd1);
    check("R1 bus reg", 32'(cfg_rdata), 32'h8400);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            {op_vec, op_valid, dq_oe, lane_en, wait_oe, wait_o},
            {10'b1 << VECS[i].x_op, VECS[i].x_valid, VECS[i].x_dq, VECS[i].x_lanes,
             VECS[i].x_woe, VECS[i].x_wo});
    end

    // R4 / R9 burst register read of refresh register after exit restore
    @(negedge clk);
    adv_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; cre = 1'b1; reg_sel = 1'b0;
    @(posedge clk); #1;
    check("R4 crd op", 32'(op_vec), 32'(10'b1 << X_CRD));
    check("R9 ref reg", 32'(cfg_rdata), 32'h0010);
    // R4 bus register still zero: DPD write was ignored (R3)
    @(negedge clk); reg_sel = 1'b1;
    @(posedge clk); #1;
    check("R3 bus reg", {dq_oe, 16'(cfg_rdata)}, {1'b1, 16'h0000});
    // R4 write bus register back to async default
    @(negedge clk); oe_n = 1'b1; we_n = 1'b0; adq_in = 16'h8400;
    @(posedge clk); #1;
    check("R4 mode back", 32'(burst_mode), 32'd0);
    // R11 combinational async read without a clock edge
    @(negedge clk);
    adv_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; cre = 1'b0; byte_sel_n = 2'b00;
    #1;
    check("R11 comb read", {op_vec, dq_oe, lane_en}, {10'b1 << X_ARD, 1'b1, 2'b11});
    // R3 standby ignores register write
    @(negedge clk); ce_n = 1'b1; cre = 1'b1; we_n = 1'b0; oe_n = 1'b1; reg_sel = 1'b1; adq_in = 16'h0000;
    @(posedge clk); #1;
    check("R3 standby write", 32'(burst_mode), 32'd0);
    // R4 async register read
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1;
    check("R4 async crd", {op_vec, dq_oe, cfg_rdata}, {10'b1 << X_CRD, 1'b1, 16'h8400});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule